// File: doc/BRIEF.md
# Half-Second Watchdog Timer

This block is a watchdog timer peripheral behind a simple synchronous 16-bit register port. It counts down a programmable timeout in half-second steps. A prescaler divides the slow timer clock into those steps, and its ratio is a parameter so that a simulation can use a short one. Software keeps the timer from expiring by writing a two-word key pair to the service register. Once the timer is running, software cannot stop it.

When the count runs out, the block requests a reset. Depending on a mode bit, that is either an internal chip-reset request or the active-low external reset pin, held for a fixed number of clocks. A sticky status bit records that a timeout happened, and only power-on reset clears it. An optional early-warning interrupt fires a programmable number of half-second steps before expiry. After boot, a separate power-down counter pulses the external reset pin low for one clock unless software disables it first.

Top module: `halfsec_wdog`

## Requirements
- R1: After reset the registers read as follows: control (address 0x0) reads 0x0030, reset status (0x4) reads 0x0000, interrupt control (0x6) reads 0x0000 and miscellaneous (0x8) reads 0x0001.
- R2: The control register holds the timeout value N in bits 15:8 and the enable in bit 2. With bit 3 at 0, setting the enable loads N+1 half-second steps. `sys_rst_req` rises exactly (N+1)·TICK_DIV clocks after the write edge and stays high for RST_HOLD clocks. `ext_rst_n` stays high.
- R3: With control bit 3 at 1, a timeout drives `ext_rst_n` low with the same timing as in R2, and `sys_rst_req` stays low.
- R4: The service register is at address 0x2. A write of 0x5555 followed, on the next service write, by 0xAAAA reloads the count to N+1 steps and restarts the step phase. Any other word, or 0x5555 while already armed, returns the sequencer to idle without a reload.
- R5: Once set, the enable (control bit 2) cannot be cleared by software. It keeps reading 1 and the countdown continues.
- R6: Control bits 0 (low-power halt) and 7 (wait halt) are taken only from the first control write after reset. While `lp_mode` is high with bit 0 set, or `wait_mode` is high with bit 7 set, half-second steps do not decrement the count.
- R7: Control bit 4 and bit 5 are active-low requests. Bit 4 at 0 holds `sys_rst_req` high, and bit 5 at 0 holds `ext_rst_n` low, for as long as the bit stays 0.
- R8: Reset status bit 1 is set by a timeout. Service writes and control writes leave it set, and only `rst_n` clears it.
- R9: Interrupt control has bit 15 as the interrupt enable, bit 14 as a status bit cleared by writing 1, and bits 7:0 as M. With the interrupt enabled and M nonzero, bit 14 and `irq` set when M steps remain, which is (N+1−M)·TICK_DIV clocks after enable.
- R10: Unless miscellaneous bit 0 is written 0 first, `ext_rst_n` goes low for exactly one clock PDN_TICKS·TICK_DIV clocks after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| lp_mode | input | 1 | Chip is in low-power mode |
| wait_mode | input | 1 | Chip is in wait mode |
| sys_rst_req | output | 1 | Internal chip-reset request, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| irq | output | 1 | Early-warning interrupt |

## Verification
The bench predicts the exact clock of each output edge from the programmed timeout and the step ratio. A prescaler that is off by one, or a count that loads N instead of N+1, therefore shows up as a mismatch in the cycle. Broken key sequences are interleaved just before a pending expiry. A sequencer that reloads on a stray 0xAAAA, or that stays armed after a wrong word, would move the timeout away from its predicted clock. The bench also tries to clear the enable and to rewrite the write-once halt bits, and it holds `lp_mode` across whole steps. A design that allows rewrites or counts during a halt would read back wrong or expire early. Finally, the early-warning interrupt is cleared by write-1 between its firing and the timeout, and the status bit is read after servicing. Either loss would appear in the readback.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam logic [3:0]  ADR_CTRL = 4'h0;
    localparam logic [3:0]  ADR_SVC  = 4'h2;
    localparam logic [3:0]  ADR_STAT = 4'h4;
    localparam logic [3:0]  ADR_ICR  = 4'h6;
    localparam logic [3:0]  ADR_MISC = 4'h8;
    localparam logic [15:0] KEY_ARM  = 16'h5555;
    localparam logic [15:0] KEY_FIRE = 16'hAAAA;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;
endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.pre == PW'(DIV - 1));
        if (restart || tick) s_d.pre = '0;
        else                 s_d.pre = s_q.pre + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (DIV > 1) begin : g_chk
            AST_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/wdog_keyseq.sv
`timescale 1ns/1ps
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        reload
);
    key_st_e st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (svc_wr) begin
            if (st_q == KEY_ARMED && svc_data == KEY_FIRE) begin
                reload = 1'b1;
                st_d   = KEY_IDLE;
            end else if (st_q == KEY_IDLE && svc_data == KEY_ARM) begin
                st_d = KEY_ARMED;
            end else begin
                st_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    AST_KEY_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q == KEY_IDLE)); // R4
    AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_wr |=> $stable(st_q)); // R4
endmodule

// File: rtl/wdog_pdn.sv
`timescale 1ns/1ps
module wdog_pdn #(
    parameter int PDN_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    output logic pulse
);
    localparam int PDN_W = $clog2(PDN_TICKS + 1);

    typedef struct packed {
        logic [PDN_W-1:0] cnt;
        logic             done;
        logic             pulse;
    } pdn_st_t;

    pdn_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (!s_q.done && tick) begin
            if (s_q.cnt == PDN_W'(PDN_TICKS - 1)) begin
                s_d.done  = 1'b1;
                s_d.pulse = arm;
            end else begin
                s_d.cnt = s_q.cnt + PDN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.pulse;

    AST_PDN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse); // R10
    AST_PDN_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> (s_q.done && !s_q.pulse)); // R10
endmodule

// File: rtl/halfsec_wdog.sv
`timescale 1ns/1ps
module halfsec_wdog
    import wdog_pkg::*;
#(
    parameter int TICK_DIV  = 16384,
    parameter int RST_HOLD  = 4,
    parameter int PDN_TICKS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        lp_mode,
    input  logic        wait_mode,
    output logic        sys_rst_req,
    output logic        ext_rst_n,
    output logic        irq
);
    localparam int TMO_W  = 8;
    localparam int CNT_W  = TMO_W + 1;
    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic              wait_halt;
        logic              ext_n;
        logic              sw_n;
        logic              mode;
        logic              en;
        logic              lp_halt;
        logic              lock;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
        logic              tout;
        logic              ie;
        logic              ist;
        logic [TMO_W-1:0]  icnt;
        logic              pdn_en;
    } wd_st_t;

    wd_st_t s_d, s_q;

    logic tick, reload, restart, pdn_pulse;
    logic wr_ctrl, wr_svc, wr_icr, wr_misc;
    logic halted, run, start;
    logic [TMO_W-1:0] next_tmo;

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_svc  = wr_en && (addr == ADR_SVC);
    assign wr_icr  = wr_en && (addr == ADR_ICR);
    assign wr_misc = wr_en && (addr == ADR_MISC);

    assign halted   = (lp_mode && s_q.lp_halt) || (wait_mode && s_q.wait_halt);
    assign run      = s_q.en && !halted;
    assign start    = wr_ctrl && wdata[2] && !s_q.en;
    assign restart  = start || reload;
    assign next_tmo = wr_ctrl ? wdata[15:8] : s_q.tmo;

    wdog_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    wdog_keyseq u_key (
        .clk(clk), .rst_n(rst_n), .svc_wr(wr_svc), .svc_data(wdata), .reload(reload)
    );

    wdog_pdn #(.PDN_TICKS(PDN_TICKS)) u_pdn (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(s_q.pdn_en), .pulse(pdn_pulse)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.hold != '0) s_d.hold = s_q.hold - HOLD_W'(1);

        if (wr_ctrl) begin
            s_d.tmo   = wdata[15:8];
            s_d.ext_n = wdata[5];
            s_d.sw_n  = wdata[4];
            s_d.mode  = wdata[3];
            if (wdata[2]) s_d.en = 1'b1;
            if (!s_q.lock) begin
                s_d.lp_halt   = wdata[0];
                s_d.wait_halt = wdata[7];
                s_d.lock      = 1'b1;
            end
        end

        if (wr_icr) begin
            s_d.ie   = wdata[15];
            s_d.icnt = wdata[7:0];
            if (wdata[14]) s_d.ist = 1'b0;
        end

        if (wr_misc && !wdata[0]) s_d.pdn_en = 1'b0;

        if (restart) begin
            s_d.cnt = {1'b0, next_tmo} + CNT_W'(1);
        end else if (tick && run) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.cnt  = {1'b0, s_q.tmo} + CNT_W'(1);
                s_d.hold = HOLD_W'(RST_HOLD);
                s_d.tout = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            if (s_q.ie && s_q.icnt != '0 && s_q.cnt == ({1'b0, s_q.icnt} + CNT_W'(1)))
                s_d.ist = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.ext_n  <= 1'b1;
            s_q.sw_n   <= 1'b1;
            s_q.pdn_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CTRL: rdata = {s_q.tmo, s_q.wait_halt, 1'b0, s_q.ext_n, s_q.sw_n,
                               s_q.mode, s_q.en, 1'b0, s_q.lp_halt};
            ADR_STAT: rdata = {14'b0, s_q.tout, 1'b0};
            ADR_ICR:  rdata = {s_q.ie, s_q.ist, 6'b0, s_q.icnt};
            ADR_MISC: rdata = {15'b0, s_q.pdn_en};
            default:  rdata = 16'h0000;
        endcase
    end

    assign sys_rst_req = ((s_q.hold != '0) && !s_q.mode) || !s_q.sw_n;
    assign ext_rst_n   = !((s_q.hold != '0) && s_q.mode) && s_q.ext_n && !pdn_pulse;
    assign irq         = s_q.ist;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en |=> s_q.en); // R5
    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tout |=> s_q.tout); // R8
    AST_TOUT_DRIVES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.tout) |-> (s_q.hold != '0)); // R8
    AST_LOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lock |=> $stable({s_q.lp_halt, s_q.wait_halt})); // R6
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && halted && !reload) |=> $stable(s_q.cnt)); // R6
    AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_icr && wdata[14] && !(tick && run)) |=> !irq); // R9
endmodule

// File: tb/sim_halfsec_wdog.sv
`timescale 1ns/1ps
module sim_halfsec_wdog;
    localparam int DIV  = 8;
    localparam int HOLD = 3;
    localparam int PDNT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic        lp_mode = 1'b0;
    logic        wait_mode = 1'b0;
    logic [15:0] rdata;
    logic        sys_rst_req, ext_rst_n, irq;

    halfsec_wdog #(.TICK_DIV(DIV), .RST_HOLD(HOLD), .PDN_TICKS(PDNT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lp_mode(lp_mode), .wait_mode(wait_mode),
        .sys_rst_req(sys_rst_req), .ext_rst_n(ext_rst_n), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    ev_t   sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    rel = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic  p_sys = 1'b0, p_ext = 1'b1, p_irq = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(int k, int at, string req);
        ev_t e;
        e.kind = k; e.at = at; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic see(int k);
        ev_t e;
        if (sbq.size() == 0) begin
            checks++; fails++;
            $display("FAIL %s: got unexpected event kind %0d at cycle %0d expected none", cur_req, k, cyc);
        end else begin
            e = sbq.pop_front();
            chk({e.req, " event kind"}, k, e.kind);
            chk({e.req, " event cycle"}, cyc, e.at);
        end
    endtask

    task automatic drain(string req);
        chk({req, " pending events"}, sbq.size(), 0);
        sbq.delete();
    endtask

    // scoreboard monitor: 0 = sys_rst_req rise, 1 = ext_rst_n fall, 2 = irq rise
    always @(negedge clk) begin
        if (sys_rst_req && !p_sys) see(0);
        if (!ext_rst_n && p_ext)   see(1);
        if (irq && !p_irq)         see(2);
        p_sys = sys_rst_req;
        p_ext = ext_rst_n;
        p_irq = irq;
    end

    task automatic wr(logic [3:0] a, logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, string req, int exp);
        addr = a; wr_en = 1'b0;
        #1;
        chk(req, int'(rdata), exp);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lp_mode = 1'b0; wait_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: R2 flow got hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int p;
        // R1 reset values, then R10 power-down pulse
        do_reset();
        cur_req = "R1";
        rd(4'h0, "R1 control", 16'h0030);
        rd(4'h4, "R1 status", 16'h0000);
        rd(4'h6, "R1 intctl", 16'h0000);
        rd(4'h8, "R1 misc", 16'h0001);
        cur_req = "R10";
        expect_ev(1, rel + PDNT * DIV, "R10");
        wait_to(rel + PDNT * DIV + 1);
        chk("R10 one-clock pulse", int'(ext_rst_n), 1);
        wait_to(rel + 90);
        drain("R10");

        // R10 disabled pulse, then R2 internal timeout and R8 status
        do_reset();
        wr(4'h8, 16'h0000);
        wait_to(rel + 70);
        drain("R10 disabled");
        cur_req = "R2";
        expect_ev(0, cyc + 1 + 4 * DIV, "R2");
        wr(4'h0, 16'h0334);
        p = cyc;
        wait_to(p + 4 * DIV + HOLD - 1);
        chk("R2 hold high", int'(sys_rst_req), 1);
        chk("R2 ext idle", int'(ext_rst_n), 1);
        wait_to(p + 4 * DIV + HOLD);
        chk("R2 hold ended", int'(sys_rst_req), 0);
        rd(4'h4, "R8 status set", 16'h0002);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        wr(4'h0, 16'h0330);
        rd(4'h4, "R8 status kept", 16'h0002);
        drain("R2");
        do_reset();
        rd(4'h4, "R8 status cleared", 16'h0000);

        // R3 external mode
        wr(4'h8, 16'h0000);
        cur_req = "R3";
        expect_ev(1, cyc + 1 + 4 * DIV, "R3");
        wr(4'h0, 16'h033C);
        p = cyc;
        wait_to(p + 4 * DIV + 1);
        chk("R3 no internal", int'(sys_rst_req), 0);
        chk("R3 ext held", int'(ext_rst_n), 0);
        wait_to(p + 4 * DIV + 6);
        drain("R3");

        // R4 service key pair and broken sequences
        do_reset();
        wr(4'h8, 16'h0000);
        cur_req = "R4";
        wr(4'h0, 16'h0334);
        p = cyc;
        wait_to(p + 20);
        wr(4'h2, 16'h5555);
        expect_ev(0, cyc + 1 + 4 * DIV, "R4");
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        wait_to(p + 60);
        drain("R4");

        // R5 enable cannot be cleared
        do_reset();
        wr(4'h8, 16'h0000);
        cur_req = "R5";
        expect_ev(0, cyc + 1 + 4 * DIV, "R5");
        wr(4'h0, 16'h0334);
        p = cyc;
        wr(4'h0, 16'h0330);
        rd(4'h0, "R5 enable readback", 16'h0334);
        wait_to(p + 40);
        drain("R5");

        // R6 write-once halt bits and low-power halt
        do_reset();
        wr(4'h8, 16'h0000);
        cur_req = "R6";
        wr(4'h0, 16'h0331);
        wr(4'h0, 16'h03B0);
        rd(4'h0, "R6 halt bits locked", 16'h0331);
        expect_ev(0, cyc + 1 + 6 * DIV, "R6");
        lp_mode = 1'b1;
        wr(4'h0, 16'h0335);
        p = cyc;
        wait_to(p + 2 * DIV);
        lp_mode = 1'b0;
        rd(4'h0, "R6 control after enable", 16'h0335);
        wait_to(p + 6 * DIV + 5);
        drain("R6");

        // R7 software request bits
        do_reset();
        wr(4'h8, 16'h0000);
        cur_req = "R7";
        expect_ev(0, cyc + 1, "R7");
        wr(4'h0, 16'h0020);
        chk("R7 internal request", int'(sys_rst_req), 1);
        wr(4'h0, 16'h0030);
        chk("R7 internal released", int'(sys_rst_req), 0);
        expect_ev(1, cyc + 1, "R7");
        wr(4'h0, 16'h0010);
        chk("R7 external request", int'(ext_rst_n), 0);
        wr(4'h0, 16'h0030);
        chk("R7 external released", int'(ext_rst_n), 1);
        repeat (2) @(negedge clk);
        drain("R7");

        // R9 early-warning interrupt
        do_reset();
        wr(4'h8, 16'h0000);
        cur_req = "R9";
        wr(4'h6, 16'h8001);
        expect_ev(2, cyc + 1 + 3 * DIV, "R9");
        expect_ev(0, cyc + 1 + 4 * DIV, "R9");
        wr(4'h0, 16'h0334);
        p = cyc;
        wait_to(p + 3 * DIV + 1);
        rd(4'h6, "R9 status set", 16'hC001);
        wr(4'h6, 16'hC001);
        chk("R9 irq cleared", int'(irq), 0);
        rd(4'h6, "R9 status cleared", 16'h8001);
        wait_to(p + 4 * DIV + 5);
        drain("R9");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule